// File: doc/BRIEF.md
# Mu-law Level Control Stage

This block conditions one pair of 8-bit mu-law samples per 8 kHz frame on the two speech paths of an echo-cancelling voice channel. The receive path (`rin_code` to `rout_code`) may pass through an automatic gain compressor. The send path (`sin_code` to `sout_code`) first has a linear echo estimate subtracted from it. A 6 dB switched attenuator then acts on one of the two paths, chosen by which talker is active. Center clipping can replace quiet send-out samples with the mu-law idle code. A through mode returns both input codes unchanged.

Each path keeps a running power estimate of its input in the linear domain. These estimates decide path activity and the receive gain. The estimator, gain and attenuator decisions for a frame use only the samples of earlier frames. Per-frame enables arrive with each sample pair on `frame_vld`. The results appear, registered, on the next clock edge.

Mu-law coding used throughout: with c = ~code, c[7]=1 means negative, c[6:4] is the segment, c[3:0] is the step, and the magnitude is ((step*8+132) << segment) - 132. The range is 0..32124, and the largest magnitude that can be encoded is 32635.

Top module: `ulaw_lvl_ctl`

## Requirements
- R1: `out_vld` is high exactly in the cycle after a cycle with `frame_vld` high. `rout_code` and `sout_code` change only on that edge and hold their values otherwise.
- R2: With `thru_en` high, `rout_code` equals `rin_code` and `sout_code` equals `sin_code` bit for bit. Gain, attenuation, clipping and the echo estimate have no effect in this mode.
- R3: In processing mode the send value is the decoded `sin_code` minus signed `echo_lin`. It is saturated to magnitude 32635 and encoded, so a zero difference gives 0xFF, full positive saturation gives 0x80 and full negative saturation gives 0x00.
- R4: With `clip_en` high in processing mode, a send-out sample whose final magnitude squared is below CLIP_PWR (default 1022, about -54 dBm0) is output as the idle code 0xFF. Magnitude 24 (code 0xFC or 0x7C) is replaced, and magnitude 32 (code 0xFB) is kept.
- R5: In processing mode with gain control and attenuation off, every `rin_code` reappears unchanged on `rout_code`, including 0x7F.
- R6: The attenuator multiplies the chosen path by 16423/32768 (6 dB), truncated. With `att_en` high exactly one path is attenuated; with it low neither is.
- R7: A path is active when its power estimate exceeds ACT_PWR (default 25680, about -40 dBm0). With `att_en` high, send-out is attenuated when only receive-in is active. In every other case (send-in silent, or both active) receive-in is attenuated.
- R8: With `agc_en` high, a receive-in power estimate below KNEE_PWR (default 2568000, about -20 dBm0) leaves the samples unscaled.
- R9: Above KNEE_PWR the receive gain falls in 0.5 dB steps: the cut is 0.5 dB times the number of thresholds KNEE_PWR*10^(k/20), k=1..17, that the estimate reaches. It is capped at 8.5 dB (factor 12316/32768) above about -11.5 dBm0. Mid-band example: a steady magnitude of 2876 is cut by 5 dB (factor 18427/32768).
- R10: Each path's power estimate is updated on every frame as p <= p - (p>>5) + ((mag*mag)>>5), using the input magnitude of that path. Decisions in a frame use the value held before that frame.
- R11: After reset `out_vld` is 0, both outputs are 0xFF and both power estimates are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_vld | input | 1 | One-cycle strobe carrying a sample pair and its enables |
| thru_en | input | 1 | Through mode for this frame |
| agc_en | input | 1 | Receive gain compressor on for this frame |
| att_en | input | 1 | Switched 6 dB attenuator on for this frame |
| clip_en | input | 1 | Send-out center clipping on for this frame |
| rin_code | input | 8 | Receive-in mu-law sample |
| sin_code | input | 8 | Send-in mu-law sample |
| echo_lin | input | 16 | Signed linear echo estimate subtracted from send-in |
| rout_code | output | 8 | Receive-out mu-law sample |
| sout_code | output | 8 | Send-out mu-law sample |
| out_vld | output | 1 | Output pair valid |

## Verification
Both output codes are due on the first rising edge after the `frame_vld` cycle. The bench therefore drives each frame on a falling edge and reads the results on the following falling edge, one register later. Activity and gain decisions depend on power estimates built from earlier frames, so each such check comes after a run of several hundred identical frames. That run lets the estimate settle well away from the relevant threshold. The check frame itself carries a sample that differs from the run where that matters. This shows that the same frame's sample does not steer its own decision.

// File: rtl/ulaw_lvl_pkg.sv
package ulaw_lvl_pkg;

  localparam int unsigned    MAG_W     = 15;
  localparam logic [14:0]    MAG_MAX   = 15'd32635;
  localparam logic [15:0]    UNITY     = 16'd32768;
  localparam int unsigned    AGC_STEPS = 17;

  typedef struct packed {
    logic             neg;
    logic [MAG_W-1:0] mag;
  } smag_t;

  // mu-law code to sign and magnitude
  function automatic smag_t ulaw_dec(input logic [7:0] code);
    logic [7:0]  c;
    logic [15:0] t;
    smag_t       r;
    c     = ~code;
    t     = ({12'd0, c[3:0]} << 3) + 16'd132;
    t     = (t << c[6:4]) - 16'd132;
    r.neg = c[7];
    r.mag = t[14:0];
    return r;
  endfunction

  // sign and magnitude to mu-law code, saturating at MAG_MAX
  function automatic logic [7:0] ulaw_enc(input smag_t s);
    logic [15:0] m;
    logic [2:0]  e;
    logic [3:0]  mt;
    m = (s.mag > MAG_MAX) ? {1'b0, MAG_MAX} : {1'b0, s.mag};
    m = m + 16'd132;
    e = 3'd0;
    for (int i = 1; i < 8; i++) begin
      if (m[i+7]) e = 3'(i);
    end
    mt = m[int'(e)+3 +: 4];
    return ~{s.neg, e, mt};
  endfunction

  // receive gain for a cut of k half-decibels, unsigned Q1.15 (32768 = 1.0)
  function automatic logic [15:0] agc_step(input int unsigned k);
    case (k)
      0:  return 16'd32768;
      1:  return 16'd30935;
      2:  return 16'd29205;
      3:  return 16'd27571;
      4:  return 16'd26029;
      5:  return 16'd24573;
      6:  return 16'd23198;
      7:  return 16'd21900;
      8:  return 16'd20675;
      9:  return 16'd19519;
      10: return 16'd18427;
      11: return 16'd17396;
      12: return 16'd16423;
      13: return 16'd15504;
      14: return 16'd14637;
      15: return 16'd13818;
      16: return 16'd13045;
      default: return 16'd12316;
    endcase
  endfunction

endpackage

// File: rtl/ulaw_lvl_avg.sv
module ulaw_lvl_avg #(
  parameter int unsigned MAG_W = 15,
  parameter int unsigned PWR_W = 32,
  parameter int unsigned SHIFT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [MAG_W-1:0] mag,
  output logic [PWR_W-1:0] pwr
);
  localparam int unsigned SQ_W = 2 * MAG_W;

  logic [SQ_W-1:0]  sq;
  logic [PWR_W-1:0] pwr_q, pwr_d;

  always_comb begin
    sq    = SQ_W'(mag) * SQ_W'(mag);
    pwr_d = pwr_q - (pwr_q >> SHIFT) + PWR_W'(sq >> SHIFT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pwr_q <= '0;
    else if (upd_en) pwr_q <= pwr_d;
  end

  assign pwr = pwr_q;
endmodule

// File: rtl/ulaw_lvl_agc.sv
module ulaw_lvl_agc
  import ulaw_lvl_pkg::*;
#(
  parameter int unsigned PWR_W    = 32,
  parameter int unsigned KNEE_PWR = 2568000
) (
  input  logic             agc_en,
  input  logic [PWR_W-1:0] pwr,
  output logic [15:0]      gain
);
  logic [AGC_STEPS-1:0] hit;

  // one comparator per half-decibel step above the knee
  for (genvar k = 1; k <= int'(AGC_STEPS); k++) begin : g_thr
    localparam logic [15:0] GK  = agc_step(k);
    localparam logic [63:0] THR = (64'(KNEE_PWR) << 30) / (64'(GK) * 64'(GK));
    assign hit[k-1] = (64'(pwr) >= THR);
  end

  always_comb begin
    gain = agc_en ? agc_step($countones(hit)) : UNITY;
  end
endmodule

// File: rtl/ulaw_lvl_ctl.sv
module ulaw_lvl_ctl
  import ulaw_lvl_pkg::*;
#(
  parameter int unsigned PWR_W     = 32,
  parameter int unsigned AVG_SHIFT = 5,
  parameter int unsigned ACT_PWR   = 25680,
  parameter int unsigned KNEE_PWR  = 2568000,
  parameter int unsigned CLIP_PWR  = 1022,
  parameter logic [15:0] ATT_GAIN  = 16'd16423
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_vld,
  input  logic              thru_en,
  input  logic              agc_en,
  input  logic              att_en,
  input  logic              clip_en,
  input  logic [7:0]        rin_code,
  input  logic [7:0]        sin_code,
  input  logic signed [15:0] echo_lin,
  output logic [7:0]        rout_code,
  output logic [7:0]        sout_code,
  output logic              out_vld
);
  smag_t             rin_s, sin_s, rout_s, sout_s;
  logic [PWR_W-1:0]  rin_pwr, sin_pwr;
  logic              rin_act, sin_act, att_on_sout, att_on_rin;
  logic [15:0]       agc_gain, rin_gain;
  logic [31:0]       gain_prod;
  logic [30:0]       rin_prod, sout_prod;
  logic signed [17:0] sin_lin, echo_x, diff;
  logic [17:0]       dabs;
  logic [14:0]       dmag;
  logic [29:0]       sout_sq;
  logic [7:0]        rout_d, sout_d, rout_q, sout_q;
  logic              vld_q;

  ulaw_lvl_avg #(.MAG_W(MAG_W), .PWR_W(PWR_W), .SHIFT(AVG_SHIFT)) u_rin_avg (
    .clk(clk), .rst_n(rst_n), .upd_en(frame_vld), .mag(rin_s.mag), .pwr(rin_pwr));

  ulaw_lvl_avg #(.MAG_W(MAG_W), .PWR_W(PWR_W), .SHIFT(AVG_SHIFT)) u_sin_avg (
    .clk(clk), .rst_n(rst_n), .upd_en(frame_vld), .mag(sin_s.mag), .pwr(sin_pwr));

  ulaw_lvl_agc #(.PWR_W(PWR_W), .KNEE_PWR(KNEE_PWR)) u_agc (
    .agc_en(agc_en), .pwr(rin_pwr), .gain(agc_gain));

  // next-state logic
  always_comb begin
    rin_s = ulaw_dec(rin_code);
    sin_s = ulaw_dec(sin_code);

    // activity from estimates of earlier frames only
    rin_act     = rin_pwr > PWR_W'(ACT_PWR);
    sin_act     = sin_pwr > PWR_W'(ACT_PWR);
    att_on_sout = att_en && rin_act && !sin_act;
    att_on_rin  = att_en && !att_on_sout;

    // receive path: compressor gain, optionally folded with the attenuator
    gain_prod  = 32'(agc_gain) * 32'(ATT_GAIN);
    rin_gain   = att_on_rin ? gain_prod[30:15] : agc_gain;
    rin_prod   = 31'(rin_s.mag) * 31'(rin_gain);
    rout_s.neg = rin_s.neg;
    rout_s.mag = rin_prod[29:15];

    // send path: subtract echo, saturate, attenuate
    sin_lin = $signed({3'b000, sin_s.mag});
    if (sin_s.neg) sin_lin = -sin_lin;
    echo_x  = {{2{echo_lin[15]}}, echo_lin};
    diff    = sin_lin - echo_x;
    dabs    = diff[17] ? 18'(-diff) : 18'(diff);
    dmag    = (dabs > 18'(MAG_MAX)) ? MAG_MAX : dabs[14:0];
    sout_prod  = 31'(dmag) * 31'(att_on_sout ? ATT_GAIN : UNITY);
    sout_s.neg = diff[17];
    sout_s.mag = sout_prod[29:15];
    sout_sq    = 30'(sout_s.mag) * 30'(sout_s.mag);

    rout_d = thru_en ? rin_code : ulaw_enc(rout_s);
    if (thru_en)                                  sout_d = sin_code;
    else if (clip_en && sout_sq < 30'(CLIP_PWR))  sout_d = 8'hFF;
    else                                          sout_d = ulaw_enc(sout_s);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rout_q <= 8'hFF;
      sout_q <= 8'hFF;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= frame_vld;
      if (frame_vld) begin
        rout_q <= rout_d;
        sout_q <= sout_d;
      end
    end
  end

  assign rout_code = rout_q;
  assign sout_code = sout_q;
  assign out_vld   = vld_q;
endmodule

// File: rtl/ulaw_lvl_chk.sv
module ulaw_lvl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_vld,
  input logic       thru_en,
  input logic       agc_en,
  input logic       att_en,
  input logic       clip_en,
  input logic [7:0] rin_code,
  input logic [7:0] sin_code,
  input logic [7:0] rout_code,
  input logic [7:0] sout_code,
  input logic       out_vld
);
  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) frame_vld |=> out_vld); // R1
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !frame_vld |=> (!out_vld && $stable(rout_code) && $stable(sout_code))); // R1
  AST_THRU_PASS: assert property (@(posedge clk) disable iff (!rst_n) (frame_vld && thru_en) |=> (rout_code == $past(rin_code) && sout_code == $past(sin_code))); // R2
  AST_CLIP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n) (frame_vld && clip_en && !thru_en) |=> (sout_code == 8'hFF || ((~sout_code) & 8'h7F) >= 8'h04)); // R4
  AST_ROUND_TRIP: assert property (@(posedge clk) disable iff (!rst_n) (frame_vld && !thru_en && !agc_en && !att_en) |=> rout_code == $past(rin_code)); // R5
  AST_AGC_NO_BOOST: assert property (@(posedge clk) disable iff (!rst_n) (frame_vld && !thru_en && !att_en) |=> (((~rout_code) & 8'h7F) <= ((~$past(rin_code)) & 8'h7F))); // R8
endmodule

bind ulaw_lvl_ctl ulaw_lvl_chk u_chk (.*);

// File: tb/ulaw_lvl_ctl_test.sv
module ulaw_lvl_ctl_test;
  logic              clk = 1'b0;
  logic              rst_n;
  logic              frame_vld, thru_en, agc_en, att_en, clip_en;
  logic [7:0]        rin_code, sin_code;
  logic signed [15:0] echo_lin;
  logic [7:0]        rout_code, sout_code;
  logic              out_vld;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ulaw_lvl_ctl uut (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .thru_en(thru_en),
    .agc_en(agc_en), .att_en(att_en), .clip_en(clip_en),
    .rin_code(rin_code), .sin_code(sin_code), .echo_lin(echo_lin),
    .rout_code(rout_code), .sout_code(sout_code), .out_vld(out_vld));

  typedef struct packed {
    logic              thru;
    logic              clip;
    logic [7:0]        rin;
    logic [7:0]        sin;
    logic signed [15:0] echo;
    logic [7:0]        x_rout;
    logic [7:0]        x_sout;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 8'h35, 8'h0E,  16'sd5000,   8'h35, 8'h0E}, // R2 echo ignored
    '{1'b1, 1'b1, 8'hFE, 8'hFC,  16'sd0,      8'hFE, 8'hFC}, // R2 clip ignored
    '{1'b0, 1'b0, 8'h35, 8'h80,  16'sd0,      8'h35, 8'h80}, // R5 R3 no echo
    '{1'b0, 1'b0, 8'h35, 8'h80,  16'sd16000,  8'h35, 8'h90}, // R3 partial cancel
    '{1'b0, 1'b0, 8'hB8, 8'h80, -16'sd20000,  8'hB8, 8'h80}, // R3 positive saturation
    '{1'b0, 1'b0, 8'h00, 8'h00,  16'sd1000,   8'h00, 8'h00}, // R3 negative saturation
    '{1'b0, 1'b0, 8'h80, 8'h80,  16'sd32124,  8'h80, 8'hFF}, // R3 full cancel
    '{1'b0, 1'b1, 8'hCF, 8'hFC,  16'sd0,      8'hCF, 8'hFF}, // R4 clipped
    '{1'b0, 1'b1, 8'hCF, 8'hFB,  16'sd0,      8'hCF, 8'hFB}, // R4 boundary kept
    '{1'b0, 1'b0, 8'hCF, 8'hFC,  16'sd0,      8'hCF, 8'hFC}, // R4 clip off
    '{1'b0, 1'b1, 8'h7C, 8'h7C,  16'sd0,      8'h7C, 8'hFF}, // R4 negative clipped
    '{1'b0, 1'b0, 8'h7F, 8'hFF,  16'sd0,      8'h7F, 8'hFF}  // R5 negative zero
  };

  // bench-side mu-law model
  function automatic int b_dec(input logic [7:0] code);
    int c, seg, stp, v;
    c   = int'(~code) & 255;
    seg = (c >> 4) & 7;
    stp = c & 15;
    v   = (2 * stp + 33) * 4 * (1 << seg) - 132;
    return (c >= 128) ? -v : v;
  endfunction

  function automatic logic [7:0] b_enc(input int lin);
    int mag, b, seg, mant;
    mag = (lin < 0) ? -lin : lin;
    if (mag > 32635) mag = 32635;
    b   = mag + 132;
    seg = 7;
    for (int s = 7; s >= 0; s--) if (b < (256 << s)) seg = s;
    mant = (b >> (seg + 3)) - 16;
    return 8'hFF ^ {(lin < 0), 3'(seg), 4'(mant)};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; frame_vld = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_frame(input logic th, input logic ag, input logic at, input logic cl,
                           input logic [7:0] r, input logic [7:0] s, input logic signed [15:0] e);
    @(negedge clk);
    thru_en = th; agc_en = ag; att_en = at; clip_en = cl;
    rin_code = r; sin_code = s; echo_lin = e; frame_vld = 1'b1;
    @(negedge clk);
    frame_vld = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; frame_vld = 1'b0; thru_en = 1'b0; agc_en = 1'b0; att_en = 1'b0;
    clip_en = 1'b0; rin_code = 8'hFF; sin_code = 8'hFF; echo_lin = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 out_vld", {7'd0, out_vld}, 8'h00);
    chk("R11 rout", rout_code, 8'hFF);
    chk("R11 sout", sout_code, 8'hFF);
    rst_n = 1'b1;

    // table walk: R2 R3 R4 R5, attenuator and gain off
    for (int i = 0; i < NV; i++) begin
      run_frame(VECS[i].thru, 1'b0, 1'b0, VECS[i].clip, VECS[i].rin, VECS[i].sin, VECS[i].echo);
      chk($sformatf("R2/R3/R4/R5 vec%0d out_vld", i), {7'd0, out_vld}, 8'h01);
      chk($sformatf("R2/R3/R4/R5 vec%0d rout", i), rout_code, VECS[i].x_rout);
      chk($sformatf("R2/R3/R4/R5 vec%0d sout", i), sout_code, VECS[i].x_sout);
    end

    // R1 hold between frames
    @(negedge clk);
    rin_code = 8'h12; sin_code = 8'h34; echo_lin = 16'sd7;
    repeat (3) @(negedge clk);
    chk("R1 idle out_vld", {7'd0, out_vld}, 8'h00);
    chk("R1 hold rout", rout_code, 8'h7F);
    chk("R1 hold sout", sout_code, 8'hFF);

    // R6 R7 R10: fresh estimates, send-in silent -> receive attenuated,
    // even though this very frame carries loud send-in
    do_reset();
    run_frame(1'b0, 1'b0, 1'b1, 1'b0, 8'h80, 8'h80, 16'sd0);
    chk("R7 R10 fresh rout", rout_code, b_enc((32124 * 16423) >>> 15));
    chk("R6 fresh sout", sout_code, 8'h80);
    // only receive-in active -> send-out attenuated
    for (int i = 0; i < 400; i++) run_frame(1'b0, 1'b0, 1'b1, 1'b0, 8'h80, 8'hFF, 16'sd0);
    run_frame(1'b0, 1'b0, 1'b1, 1'b0, 8'h80, 8'h80, 16'sd0);
    chk("R7 rin-only rout", rout_code, 8'h80);
    chk("R7 rin-only sout", sout_code, b_enc((32124 * 16423) >>> 15));
    // both active -> receive attenuated
    for (int i = 0; i < 400; i++) run_frame(1'b0, 1'b0, 1'b1, 1'b0, 8'h80, 8'h80, 16'sd0);
    run_frame(1'b0, 1'b0, 1'b1, 1'b0, 8'h80, 8'h80, 16'sd0);
    chk("R7 both rout", rout_code, b_enc((32124 * 16423) >>> 15));
    chk("R7 both sout", sout_code, 8'h80);
    // R6 attenuator off -> neither path cut
    run_frame(1'b0, 1'b0, 1'b0, 1'b0, 8'h80, 8'h80, 16'sd0);
    chk("R6 off rout", rout_code, 8'h80);
    chk("R6 off sout", sout_code, 8'h80);
    // only send-in active -> receive attenuated
    for (int i = 0; i < 600; i++) run_frame(1'b0, 1'b0, 1'b1, 1'b0, 8'hFF, 8'h80, 16'sd0);
    run_frame(1'b0, 1'b0, 1'b1, 1'b0, 8'h80, 8'h80, 16'sd0);
    chk("R7 sin-only rout", rout_code, b_enc((32124 * 16423) >>> 15));
    chk("R7 sin-only sout", sout_code, 8'h80);

    // R8: quiet steady receive level stays unscaled
    do_reset();
    run_frame(1'b0, 1'b1, 1'b0, 1'b0, 8'h80, 8'hFF, 16'sd0);
    chk("R8 fresh estimate rout", rout_code, 8'h80);
    for (int i = 0; i < 400; i++) run_frame(1'b0, 1'b1, 1'b0, 1'b0, 8'hCF, 8'hFF, 16'sd0);
    run_frame(1'b0, 1'b1, 1'b0, 1'b0, 8'hCF, 8'hFF, 16'sd0);
    chk("R8 below knee rout", rout_code, 8'hCF);

    // R9: loud steady level gets the 8.5 dB ceiling
    do_reset();
    for (int i = 0; i < 400; i++) run_frame(1'b0, 1'b1, 1'b0, 1'b0, 8'h80, 8'hFF, 16'sd0);
    run_frame(1'b0, 1'b1, 1'b0, 1'b0, 8'h80, 8'hFF, 16'sd0);
    chk("R9 ceiling rout", rout_code, b_enc((b_dec(8'h80) * 12316) >>> 15));

    // R9: mid-band level (magnitude 2876) gets a 5 dB cut
    do_reset();
    for (int i = 0; i < 400; i++) run_frame(1'b0, 1'b1, 1'b0, 1'b0, 8'hB8, 8'hFF, 16'sd0);
    run_frame(1'b0, 1'b1, 1'b0, 1'b0, 8'hB8, 8'hFF, 16'sd0);
    chk("R9 mid-band rout", rout_code, b_enc((b_dec(8'hB8) * 18427) >>> 15));

    done = 1'b1;
    summary();
    $finish;
  end
endmodule